// File: doc/BRIEF.md
# Segmented Host Port for a 64-bit Lookup Table

This block is the synchronous host-side front end of a 64-bit exact-match lookup table. The host reaches 64-bit words and registers through a 32-bit data port. A segment input picks the lower or upper half. One shared input bus carries either a table address or a control code, and a qualifier line says which of the two it is. Each host cycle starts when the active-low cycle enable falls. The block turns that cycle into one strobe towards the array: a memory read or write, a register read or write, or a validity set or clear. Writing the upper half of the comparand launches a compare.

The block does not drive a bidirectional bus itself. It drives a read value and a drive-enable, and it releases the bus while the enable is high. The result index (from a compare, or the address of the last memory access) is held steady while the enable is low. It moves to the output only while the enable is high, and a separate active-low output enable gates it. When a configuration bit selects software control, the address/control input and its qualifier are ignored. The code is taken from an instruction register instead.

Top module: `hif_host_if`

## Requirements
- R1: After reset all strobes, `seg_err`, `cmp_stb`, `dq_drive`, `idx_out`, `cmp_key` and `cmp_mask` are zero, and software control is off.
- R2: A host cycle is taken only at a clock edge where `en_n` is sampled low after being sampled high. Its strobe is high for exactly one cycle, starting one cycle later, however long `en_n` stays low.
- R3: With `ac_qual` low, a write cycle (`wr_n` low) gives `mem_wr_stb` and a read cycle gives `mem_rd_stb`. Either strobe carries `mem_addr` = captured bus, `mem_seg_hi` = captured segment, and `mem_wdata` = data captured at the enable edge.
- R4: With `ac_qual` high, the code is decoded as follows. Bits 3:0 are the operation: 1 = register access, 2 = set valid, 3 = clear valid, others = no operation. Bits 5:4 select the register: 0 = comparand (64-bit), 1 = mask (64-bit), 2 = configuration (32-bit), 3 = instruction (32-bit). Set and clear valid present the address of the last memory access on `mem_addr`.
- R5: On a 64-bit register, segment low reaches bits 31:0 and segment high reaches bits 63:32. Read data appears on `dq_out` one cycle after the strobe; memory reads return the selected half of `mem_rdata`.
- R6: A register access with segment high to a 32-bit register pulses `seg_err` one cycle after the strobe. A write is dropped; a read returns zero.
- R7: A write to the upper half of the comparand pulses `cmp_stb` one cycle later, with `cmp_key` and `cmp_mask` holding the full 64-bit values. A lower-half write launches nothing.
- R8: `dq_drive` is high only while `en_n` is low and `wr_n` is high.
- R9: `idx_out` does not change across any clock edge at which `en_n` is low. `idx_drive` equals the inverse of `oe_n`.
- R10: The pending index takes `res_idx` when `res_vld` is high. Otherwise it takes the address of a memory strobe. When both happen in the same cycle, `res_idx` wins.
- R11: When configuration bit 0 is set, the qualifier and code come from the instruction register (bit 13 = qualifier, bits 12:0 = code), and `ac_qual`/`ac_bus` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low host cycle enable |
| wr_n | input | 1 | Low = write, high = read |
| seg_hi | input | 1 | Segment select: 0 = bits 31:0, 1 = bits 63:32 |
| ac_qual | input | 1 | 0 = bus is an address, 1 = bus is a control code |
| ac_bus | input | 13 | Shared address/control bus |
| dq_in | input | 32 | Host write data |
| dq_out | output | 32 | Host read data |
| dq_drive | output | 1 | Data bus drive enable |
| oe_n | input | 1 | Active-low result index output enable |
| idx_out | output | 13 | Result index |
| idx_drive | output | 1 | Result index drive enable |
| mem_rd_stb | output | 1 | Array read strobe |
| mem_wr_stb | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array address |
| mem_seg_hi | output | 1 | Array half select |
| mem_wdata | output | 32 | Array write data |
| mem_rdata | input | 64 | Array read data, valid with the read strobe |
| vld_set_stb | output | 1 | Set validity at `mem_addr` |
| vld_clr_stb | output | 1 | Clear validity at `mem_addr` |
| cmp_stb | output | 1 | Compare launch |
| cmp_key | output | 64 | Comparand |
| cmp_mask | output | 64 | Compare mask |
| res_vld | input | 1 | Array result valid |
| res_idx | input | 13 | Array result index |
| seg_err | output | 1 | Segment error pulse |

## Verification
Two things can land in the same cycle: a memory access, which offers its address as the next index, and a result arriving from the array. The bench raises `res_vld` in exactly the cycle that a memory write strobe is issued. After the enable is released, it expects `idx_out` to carry the array result rather than the address. The same scenario also holds the enable low while the new index is already pending, and checks that the old index stays on the output until the enable rises.

// File: rtl/hif_pkg.sv
package hif_pkg;

   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_REG  = 4'd1,
      OP_VSET = 4'd2,
      OP_VCLR = 4'd3
   } op_e;

   typedef enum logic [1:0] {
      RG_KEY   = 2'd0,
      RG_MASK  = 2'd1,
      RG_CFG   = 2'd2,
      RG_INSTR = 2'd3
   } rid_e;

   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic reg_rd;
      logic reg_wr;
      logic vset;
      logic vclr;
   } strb_t;

endpackage

// File: rtl/hif_capture.sv
module hif_capture #(
   parameter int ADR_W = 13,
   parameter int DQ_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_n,
   input  logic             qual,
   input  logic             seg_hi,
   input  logic             wr_n,
   input  logic [ADR_W-1:0] ac,
   input  logic [DQ_W-1:0]  dq_in,
   output logic             cap_vld,
   output logic             cap_qual,
   output logic             cap_seg,
   output logic             cap_wr,
   output logic [ADR_W-1:0] cap_ac,
   output logic [DQ_W-1:0]  cap_dq
);

   logic en_prev;
   logic start;

   // a cycle begins where the enable is first seen low
   assign start = en_prev & ~en_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev  <= 1'b1;
         cap_vld  <= 1'b0;
         cap_qual <= 1'b0;
         cap_seg  <= 1'b0;
         cap_wr   <= 1'b0;
         cap_ac   <= '0;
         cap_dq   <= '0;
      end else begin
         en_prev <= en_n;
         cap_vld <= start;
         if (start) begin
            cap_qual <= qual;
            cap_seg  <= seg_hi;
            cap_wr   <= ~wr_n;
            cap_ac   <= ac;
            cap_dq   <= dq_in;
         end
      end
   end

   // R2: one capture per enable low period
   p_single_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld |=> !cap_vld);

endmodule

// File: rtl/hif_decode.sv
module hif_decode
   import hif_pkg::*;
#(
   parameter int ADR_W   = 13,
   parameter bit SOFT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_vld,
   input  logic             cap_qual,
   input  logic             cap_wr,
   input  logic [ADR_W-1:0] cap_ac,
   input  logic             soft_mode,
   input  logic [ADR_W:0]   instr_code,
   output strb_t            strb,
   output rid_e             rid,
   output logic [ADR_W-1:0] mem_addr
);

   logic             eff_qual;
   logic [ADR_W-1:0] eff_code;
   logic [ADR_W-1:0] addr_q;
   op_e              op;

   generate
      if (SOFT_EN) begin : g_soft
         assign eff_qual = soft_mode ? instr_code[ADR_W] : cap_qual;
         assign eff_code = soft_mode ? instr_code[ADR_W-1:0] : cap_ac;
      end else begin : g_hw
         logic unused_soft;
         assign unused_soft = ^{soft_mode, instr_code};
         assign eff_qual = cap_qual;
         assign eff_code = cap_ac;
      end
   endgenerate

   assign op  = op_e'(eff_code[3:0]);
   assign rid = rid_e'(eff_code[5:4]);

   always_comb begin
      strb = '0;
      if (cap_vld) begin
         if (!eff_qual) begin
            strb.mem_wr = cap_wr;
            strb.mem_rd = ~cap_wr;
         end else begin
            case (op)
               OP_REG: begin
                  strb.reg_wr = cap_wr;
                  strb.reg_rd = ~cap_wr;
               end
               OP_VSET: strb.vset = 1'b1;
               OP_VCLR: strb.vclr = 1'b1;
               default: ;
            endcase
         end
      end
   end

   // last memory address, target of validity operations
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (cap_vld && !eff_qual)
         addr_q <= eff_code;
   end

   assign mem_addr = (strb.vset || strb.vclr) ? addr_q : eff_code;

   // R4: validity strobes appear only on decoded control cycles
   p_vld_needs_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.vset || strb.vclr) |-> (cap_vld && !strb.mem_wr && !strb.mem_rd));

endmodule

// File: rtl/hif_regs.sv
module hif_regs
   import hif_pkg::*;
#(
   parameter int DQ_W  = 32,
   parameter int KEY_W = 64,
   parameter int ADR_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic             mem_rd,
   input  rid_e             rid,
   input  logic             seg,
   input  logic [DQ_W-1:0]  wdata,
   input  logic [KEY_W-1:0] mem_rdata,
   output logic [DQ_W-1:0]  rd_q,
   output logic             err_stb,
   output logic             cmp_stb,
   output logic [KEY_W-1:0] key,
   output logic [KEY_W-1:0] mask,
   output logic             soft_mode,
   output logic [ADR_W:0]   instr_code
);

   localparam int SEGS = KEY_W / DQ_W;

   logic [SEGS-1:0][DQ_W-1:0] key_q;
   logic [SEGS-1:0][DQ_W-1:0] mask_q;
   logic [DQ_W-1:0]           cfg_q;
   logic [DQ_W-1:0]           instr_q;
   logic                      narrow;
   logic                      bad;
   logic [DQ_W-1:0]           rsel;
   logic [DQ_W-1:0]           mem_half;
   logic                      unused_bits;

   assign narrow = (rid == RG_CFG) || (rid == RG_INSTR);
   assign bad    = (reg_wr || reg_rd) && narrow && seg;

   generate
      for (genvar g = 0; g < SEGS; g++) begin : g_half
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               key_q[g]  <= '0;
               mask_q[g] <= '0;
            end else if (reg_wr && (int'(seg) == g)) begin
               if (rid == RG_KEY)  key_q[g]  <= wdata;
               if (rid == RG_MASK) mask_q[g] <= wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         instr_q <= '0;
      end else if (reg_wr && !seg) begin
         if (rid == RG_CFG)   cfg_q   <= wdata;
         if (rid == RG_INSTR) instr_q <= wdata;
      end
   end

   always_comb begin
      case (rid)
         RG_KEY:   rsel = key_q[seg];
         RG_MASK:  rsel = mask_q[seg];
         RG_CFG:   rsel = seg ? '0 : cfg_q;
         default:  rsel = seg ? '0 : instr_q;
      endcase
   end

   assign mem_half = seg ? mem_rdata[KEY_W-1:DQ_W] : mem_rdata[DQ_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         err_stb <= 1'b0;
         cmp_stb <= 1'b0;
      end else begin
         if (reg_rd)
            rd_q <= rsel;
         else if (mem_rd)
            rd_q <= mem_half;
         err_stb <= bad;
         cmp_stb <= reg_wr && (rid == RG_KEY) && seg;
      end
   end

   assign key         = key_q;
   assign mask        = mask_q;
   assign soft_mode   = cfg_q[0];
   assign instr_code  = instr_q[ADR_W:0];
   assign unused_bits = ^{cfg_q[DQ_W-1:1], instr_q[DQ_W-1:ADR_W+1]};

   // R7: compare launches only after an upper comparand write
   p_cmp_after_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_stb |-> $past(reg_wr && rid == RG_KEY && seg));

   // R6: a flagged access leaves the narrow registers untouched
   p_err_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_stb |-> ($stable(cfg_q) && $stable(instr_q)));

endmodule

// File: rtl/hif_result.sv
module hif_result #(
   parameter int ADR_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_n,
   input  logic             load,
   input  logic [ADR_W-1:0] addr,
   input  logic             res_vld,
   input  logic [ADR_W-1:0] res_idx,
   output logic [ADR_W-1:0] idx_q
);

   logic [ADR_W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         idx_q  <= '0;
      end else begin
         if (res_vld)
            pend_q <= res_idx;
         else if (load)
            pend_q <= addr;
         if (en_n)
            idx_q <= pend_q;
      end
   end

   // R9: index frozen across edges with the enable low
   p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_n |=> $stable(idx_q));

   // R10: array result takes precedence
   p_array_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> (pend_q == $past(res_idx)));

endmodule

// File: rtl/hif_host_if.sv
module hif_host_if
   import hif_pkg::*;
#(
   parameter int ADR_W   = 13,
   parameter int DQ_W    = 32,
   parameter int KEY_W   = 64,
   parameter bit SOFT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_n,
   input  logic             wr_n,
   input  logic             seg_hi,
   input  logic             ac_qual,
   input  logic [ADR_W-1:0] ac_bus,
   input  logic [DQ_W-1:0]  dq_in,
   output logic [DQ_W-1:0]  dq_out,
   output logic             dq_drive,
   input  logic             oe_n,
   output logic [ADR_W-1:0] idx_out,
   output logic             idx_drive,
   output logic             mem_rd_stb,
   output logic             mem_wr_stb,
   output logic [ADR_W-1:0] mem_addr,
   output logic             mem_seg_hi,
   output logic [DQ_W-1:0]  mem_wdata,
   input  logic [KEY_W-1:0] mem_rdata,
   output logic             vld_set_stb,
   output logic             vld_clr_stb,
   output logic             cmp_stb,
   output logic [KEY_W-1:0] cmp_key,
   output logic [KEY_W-1:0] cmp_mask,
   input  logic             res_vld,
   input  logic [ADR_W-1:0] res_idx,
   output logic             seg_err
);

   generate
      if (KEY_W != 2 * DQ_W) begin : g_chk_key
         $error("KEY_W must be twice DQ_W");
      end
      if (ADR_W < 6 || ADR_W + 1 >= DQ_W) begin : g_chk_adr
         $error("ADR_W must hold a control code and fit an instruction word");
      end
   endgenerate

   logic             cap_vld;
   logic             cap_qual;
   logic             cap_seg;
   logic             cap_wr;
   logic [ADR_W-1:0] cap_ac;
   logic [DQ_W-1:0]  cap_dq;
   strb_t            strb;
   rid_e             rid;
   logic             soft_mode;
   logic [ADR_W:0]   instr_code;

   hif_capture #(.ADR_W(ADR_W), .DQ_W(DQ_W)) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_n     (en_n),
      .qual     (ac_qual),
      .seg_hi   (seg_hi),
      .wr_n     (wr_n),
      .ac       (ac_bus),
      .dq_in    (dq_in),
      .cap_vld  (cap_vld),
      .cap_qual (cap_qual),
      .cap_seg  (cap_seg),
      .cap_wr   (cap_wr),
      .cap_ac   (cap_ac),
      .cap_dq   (cap_dq)
   );

   hif_decode #(.ADR_W(ADR_W), .SOFT_EN(SOFT_EN)) i_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_vld    (cap_vld),
      .cap_qual   (cap_qual),
      .cap_wr     (cap_wr),
      .cap_ac     (cap_ac),
      .soft_mode  (soft_mode),
      .instr_code (instr_code),
      .strb       (strb),
      .rid        (rid),
      .mem_addr   (mem_addr)
   );

   hif_regs #(.DQ_W(DQ_W), .KEY_W(KEY_W), .ADR_W(ADR_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (strb.reg_wr),
      .reg_rd     (strb.reg_rd),
      .mem_rd     (strb.mem_rd),
      .rid        (rid),
      .seg        (cap_seg),
      .wdata      (cap_dq),
      .mem_rdata  (mem_rdata),
      .rd_q       (dq_out),
      .err_stb    (seg_err),
      .cmp_stb    (cmp_stb),
      .key        (cmp_key),
      .mask       (cmp_mask),
      .soft_mode  (soft_mode),
      .instr_code (instr_code)
   );

   hif_result #(.ADR_W(ADR_W)) i_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_n    (en_n),
      .load    (strb.mem_rd | strb.mem_wr),
      .addr    (mem_addr),
      .res_vld (res_vld),
      .res_idx (res_idx),
      .idx_q   (idx_out)
   );

   assign mem_rd_stb  = strb.mem_rd;
   assign mem_wr_stb  = strb.mem_wr;
   assign mem_seg_hi  = cap_seg;
   assign mem_wdata   = cap_dq;
   assign vld_set_stb = strb.vset;
   assign vld_clr_stb = strb.vclr;
   assign dq_drive    = ~en_n & wr_n;
   assign idx_drive   = ~oe_n;

   // R3: memory strobes never overlap
   p_mem_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_stb, mem_wr_stb, vld_set_stb, vld_clr_stb}));

endmodule

// File: tb/test_hif_host_if.sv
module test_hif_host_if;

   localparam int CLK_T = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        seg_hi = 1'b0;
   logic        ac_qual = 1'b0;
   logic [12:0] ac_bus = '0;
   logic [31:0] dq_in = '0;
   logic [31:0] dq_out;
   logic        dq_drive;
   logic        oe_n = 1'b1;
   logic [12:0] idx_out;
   logic        idx_drive;
   logic        mem_rd_stb, mem_wr_stb, mem_seg_hi;
   logic [12:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [63:0] mem_rdata;
   logic        vld_set_stb, vld_clr_stb, cmp_stb, seg_err;
   logic [63:0] cmp_key, cmp_mask;
   logic        res_vld = 1'b0;
   logic [12:0] res_idx = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // array model: read data derived from the address
   assign mem_rdata = {32'hA500_0000 ^ {19'b0, mem_addr}, 32'h5A00_0000 ^ {19'b0, mem_addr}};

   always #(CLK_T / 2) clk = ~clk;

   hif_host_if i_hif_host_if (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .wr_n(wr_n), .seg_hi(seg_hi),
      .ac_qual(ac_qual), .ac_bus(ac_bus), .dq_in(dq_in), .dq_out(dq_out),
      .dq_drive(dq_drive), .oe_n(oe_n), .idx_out(idx_out), .idx_drive(idx_drive),
      .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb), .mem_addr(mem_addr),
      .mem_seg_hi(mem_seg_hi), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .vld_set_stb(vld_set_stb), .vld_clr_stb(vld_clr_stb), .cmp_stb(cmp_stb),
      .cmp_key(cmp_key), .cmp_mask(cmp_mask), .res_vld(res_vld),
      .res_idx(res_idx), .seg_err(seg_err)
   );

   // snapshots: s1 = strobe cycle, s2 = cycle after
   logic        s1_mw, s1_mr, s1_vs, s1_vc, s1_seg;
   logic [12:0] s1_addr;
   logic [31:0] s1_wd;
   logic        s2_err, s2_cmp, s2_drv;
   logic [31:0] s2_dq;
   logic [12:0] s2_idx;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      en_n = 1'b1;
      wr_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic hcyc(input logic q, input logic [12:0] code, input logic s,
                       input logic w, input logic [31:0] d,
                       input logic inj, input logic [12:0] inj_idx);
      @(negedge clk);
      en_n = 1'b0; ac_qual = q; ac_bus = code; seg_hi = s; wr_n = ~w; dq_in = d;
      @(posedge clk); #1;
      s1_mw = mem_wr_stb; s1_mr = mem_rd_stb; s1_vs = vld_set_stb;
      s1_vc = vld_clr_stb; s1_addr = mem_addr; s1_seg = mem_seg_hi; s1_wd = mem_wdata;
      if (inj) begin res_vld = 1'b1; res_idx = inj_idx; end
      @(posedge clk); #1;
      res_vld = 1'b0;
      s2_err = seg_err; s2_cmp = cmp_stb; s2_dq = dq_out; s2_drv = dq_drive; s2_idx = idx_out;
      @(negedge clk);
      en_n = 1'b1; wr_n = 1'b1; ac_bus = 13'h1FFF; dq_in = 32'hFFFF_FFFF;
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      check("R1 dq_drive", dq_drive, 0);
      check("R1 idx_out", idx_out, 0);
      check("R1 strobes", {mem_rd_stb, mem_wr_stb, vld_set_stb, vld_clr_stb, cmp_stb, seg_err}, 0);
      check("R1 key/mask", {cmp_key, cmp_mask} == 128'h0, 1);
   endtask

   task automatic t_mem();
      hcyc(0, 13'h0456, 1, 1, 32'hDEAD_BEEF, 0, 0);
      check("R3 wr strobe", {s1_mw, s1_mr}, 2'b10);
      check("R3 wr addr", s1_addr, 13'h0456);
      check("R3 wr seg", s1_seg, 1);
      check("R3 wr data", s1_wd, 32'hDEAD_BEEF);
      hcyc(0, 13'h0123, 1, 0, 0, 0, 0);
      check("R3 rd strobe", {s1_mw, s1_mr}, 2'b01);
      check("R5 mem rd hi", s2_dq, 32'hA500_0123);
      hcyc(0, 13'h0123, 0, 0, 0, 0, 0);
      check("R5 mem rd lo", s2_dq, 32'h5A00_0123);
   endtask

   task automatic t_hold();
      int cnt = 0;
      @(negedge clk);
      en_n = 1'b0; ac_qual = 0; ac_bus = 13'h0011; wr_n = 1'b0; seg_hi = 0;
      for (int i = 0; i < 5; i++) begin
         @(posedge clk); #1;
         if (mem_wr_stb) cnt++;
      end
      @(negedge clk); en_n = 1'b1; wr_n = 1'b1;
      @(posedge clk); #1;
      check("R2 one strobe per low period", cnt, 1);
   endtask

   task automatic t_valid();
      hcyc(0, 13'h0777, 0, 1, 32'h1, 0, 0);
      hcyc(1, 13'h0002, 0, 1, 0, 0, 0);
      check("R4 vset strobe", {s1_vs, s1_vc, s1_mw}, 3'b100);
      check("R4 vset addr", s1_addr, 13'h0777);
      hcyc(1, 13'h0003, 0, 0, 0, 0, 0);
      check("R4 vclr strobe", {s1_vs, s1_vc, s1_mr}, 3'b010);
      check("R4 vclr addr", s1_addr, 13'h0777);
      hcyc(1, 13'h0009, 0, 1, 0, 0, 0);
      check("R4 nop code", {s1_vs, s1_vc, s1_mw, s1_mr, s2_err, s2_cmp}, 0);
   endtask

   task automatic t_regs64();
      hcyc(1, 13'h0011, 0, 1, 32'h0F0F_0F0F, 0, 0);
      hcyc(1, 13'h0011, 1, 1, 32'hF0F0_F0F0, 0, 0);
      hcyc(1, 13'h0001, 0, 1, 32'h1111_2222, 0, 0);
      check("R7 lo write no launch", s2_cmp, 0);
      hcyc(1, 13'h0001, 1, 1, 32'h3333_4444, 0, 0);
      check("R7 hi write launches", s2_cmp, 1);
      check("R7 key", cmp_key, 64'h3333_4444_1111_2222);
      check("R7 mask", cmp_mask, 64'hF0F0_F0F0_0F0F_0F0F);
      hcyc(1, 13'h0001, 0, 0, 0, 0, 0);
      check("R5 key rd lo", s2_dq, 32'h1111_2222);
      check("R8 drive on read", s2_drv, 1);
      hcyc(1, 13'h0001, 1, 0, 0, 0, 0);
      check("R5 key rd hi", s2_dq, 32'h3333_4444);
      hcyc(1, 13'h0011, 1, 0, 0, 0, 0);
      check("R5 mask rd hi", s2_dq, 32'hF0F0_F0F0);
      check("R8 released after cycle", dq_drive, 0);
   endtask

   task automatic t_err();
      hcyc(1, 13'h0021, 1, 1, 32'h0000_0001, 0, 0);
      check("R6 err on hi write", s2_err, 1);
      check("R8 no drive on write", s2_drv, 0);
      hcyc(1, 13'h0021, 0, 0, 0, 0, 0);
      check("R6 write dropped", s2_dq, 0);
      check("R6 no err on lo", s2_err, 0);
      hcyc(1, 13'h0031, 0, 1, 32'h0000_0ABC, 0, 0);
      hcyc(1, 13'h0031, 1, 0, 0, 0, 0);
      check("R6 err on hi read", s2_err, 1);
      check("R6 hi read zero", s2_dq, 0);
   endtask

   task automatic t_index();
      oe_n = 1'b1; #1;
      check("R9 idx_drive off", idx_drive, 0);
      oe_n = 1'b0; #1;
      check("R9 idx_drive on", idx_drive, 1);
      hcyc(0, 13'h00AB, 0, 1, 0, 0, 0);
      check("R9 index after release", idx_out, 13'h00AB);
      hcyc(0, 13'h0077, 0, 1, 0, 1, 13'h1F0);
      check("R9 index held while low", s2_idx, 13'h00AB);
      check("R10 array result wins", idx_out, 13'h1F0);
   endtask

   task automatic t_soft();
      hcyc(1, 13'h0031, 0, 1, 32'h0000_0005, 0, 0);
      hcyc(1, 13'h0021, 0, 1, 32'h0000_0001, 0, 0);
      hcyc(1, 13'h0002, 0, 1, 32'h0000_0042, 0, 0);
      check("R11 bus ignored", {s1_mw, s1_vs}, 2'b10);
      check("R11 instr addr", s1_addr, 13'h0005);
      do_reset();
   endtask

   initial begin
      #(CLK_T * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_reset();
      t_mem();
      t_hold();
      t_valid();
      t_regs64();
      t_err();
      t_index();
      t_soft();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule